// File: doc/BRIEF.md
# Shift-Register Serial Pattern Generator

The block produces a pair of serial waveforms, typically a serial clock and a serial data line, from one wide active shift register. Software fills two shadow data words through a simple write port. The shadow words are copied into the active register when the generator is switched on and again when a burst is started. During a burst the active register moves one place to the right for every shift-tick pulse, for a programmed number of shifts. The data output and the clock output each follow their own fixed tap bit of the active register. Putting a clock pattern beside the data bits, and the wanted idle level in the first bit of the high word, gives a serial bus frame with a chosen clock polarity and phase.

Two end-of-burst policies are offered. In shift-once mode, zeros fill from the top and the register is left as shifted, so both lines rest at whatever bits have reached their taps. In rotate-once mode, the bit leaving position 0 re-enters at the top. On the final shift the register is reloaded from the shadow words, so the lines rest at the first bits of the pattern. While the generator is disabled both outputs are held low.

Top module: `serial_pattern_gen`

## Requirements
- R1: After synchronous reset, `busy`, `data_out` and `clk_out` are all 0.
- R2: In any cycle that follows a clock edge at which `enable` was 0, both `data_out` and `clk_out` are 0.
- R3: A write with `wr_sel`=0 sets shadow bits 0..REG_W-1, and a write with `wr_sel`=1 sets shadow bits REG_W..2*REG_W-1. A write never changes the active register or the outputs until the next load.
- R4: On the edge at which `enable` is first seen high after being low, the active register is loaded from the shadows. From the next cycle `data_out` equals active bit DATA_TAP and `clk_out` equals active bit CLK_TAP.
- R5: A `start` pulse is accepted only when `enable` is 1, `busy` is 0 and `bit_len` is nonzero. It loads the active register from the shadows and raises `busy` in the next cycle. Any other `start` is ignored.
- R6: Each `shift_tick` pulse during a burst moves the active register right by one place. Cycles without a tick leave the register unchanged.
- R7: With `mode`=0 (shift-once), a 0 enters the top bit. After `bit_len` ticks `busy` falls and the register keeps its shifted contents, with no reload.
- R8: With `mode`=1 (rotate-once), the bit leaving position 0 enters the top bit. On the `bit_len`-th tick the register is reloaded from the shadows and `busy` falls.
- R9: `bit_len` and `mode` are captured when a burst starts. Changing them, or pulsing `start`, during the burst has no effect on that burst.
- R10: Dropping `enable` during a burst ends it, so `busy` is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Shadow word write strobe |
| wr_sel | input | 1 | Shadow word select: 0 low word, 1 high word |
| wr_data | input | REG_W | Write data |
| bit_len | input | LEN_W | Number of shifts per burst |
| mode | input | 1 | 0 shift-once, 1 rotate-once |
| enable | input | 1 | Generator enable |
| start | input | 1 | Burst start strobe |
| shift_tick | input | 1 | One-cycle shift enable pulse |
| data_out | output | 1 | Serial data line (active bit DATA_TAP) |
| clk_out | output | 1 | Serial clock line (active bit CLK_TAP) |
| busy | output | 1 | Burst in progress |

## Verification
The bench builds the block with REG_W=8, DATA_TAP=0 and CLK_TAP=4, so the active register is 16 bits wide. At this size every burst length from 1 to 16 can be swept in both modes with two patterns each, and the bench predicts each tap value arithmetically from the shift count. The narrow register also puts the end-of-burst resting levels, the top-bit fill, the full-width rotation and the small-scale clock-idle example within a few cycles. Disable-during-burst, writes during a burst, and ignored starts are each driven as directed cases.

// File: rtl/spg_pkg.sv
// Package: shared types for the serial pattern generator.
// Assumes: included first in compile order.
package spg_pkg;
    typedef enum logic {
        SPG_MODE_SHIFT  = 1'b0,
        SPG_MODE_ROTATE = 1'b1
    } spg_mode_e;
endpackage

// File: rtl/spg_shadow_regs.sv
// Module: spg_shadow_regs
// Holds the two shadow data words that software writes. It presents them as
// one concatenated image, with the low word in the low bits.
// Assumes: single-cycle write strobe; wr_sel picks the word.
module spg_shadow_regs #(
    parameter int REG_W = 32,
    localparam int IMG_W = 2 * REG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    output logic [IMG_W-1:0] image
);
    for (genvar gi = 0; gi < 2; gi++) begin : g_word
        logic [REG_W-1:0] word_q;
        // Capture a write addressed to this word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q <= '0;
            else if (wr_en && (wr_sel == 1'(gi)))
                word_q <= wr_data;
        end
        assign image[gi*REG_W +: REG_W] = word_q;
    end

    assert_low_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel) |=> (image[REG_W-1:0] == $past(wr_data)));
    assert_high_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel) |=> (image[IMG_W-1:REG_W] == $past(wr_data)));
endmodule

// File: rtl/spg_burst_ctrl.sv
// Module: spg_burst_ctrl
// Sequences a burst. It accepts starts, counts shift ticks and decides when
// the active register loads, shifts or reloads. It also tracks the registered
// enable that gates the outputs.
// Assumes: shift_tick is a one-cycle pulse; bit_len of 0 is never started.
module spg_burst_ctrl #(
    parameter int LEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             start,
    input  logic             tick,
    input  logic [LEN_W-1:0] bit_len,
    input  spg_pkg::spg_mode_e mode,
    output logic             busy,
    output logic             out_en,
    output logic             load_req,
    output logic             shift_req,
    output logic             shift_rot
);
    import spg_pkg::*;

    logic             en_q;
    logic             busy_q;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] len_q;
    spg_mode_e        mode_q;

    logic start_ok;
    logic last_tick;
    logic en_rise;
    logic rot_end;

    // Decode the accept, end-of-burst and enable-edge conditions.
    always_comb begin
        start_ok  = enable && start && !busy_q && (bit_len != '0);
        last_tick = busy_q && enable && tick && (cnt_q == len_q - 1'b1);
        en_rise   = enable && !en_q;
        rot_end   = last_tick && (mode_q == SPG_MODE_ROTATE);
        load_req  = en_rise || start_ok || rot_end;
        shift_req = busy_q && enable && tick && !rot_end;
    end

    // Track the enable level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= 1'b0;
        else
            en_q <= enable;
    end

    // Burst state: busy flag, shift counter and the captured settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            len_q  <= '0;
            mode_q <= SPG_MODE_SHIFT;
        end else if (!enable) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_ok) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            len_q  <= bit_len;
            mode_q <= mode;
        end else if (busy_q && tick) begin
            if (last_tick) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy      = busy_q;
    assign out_en    = en_q;
    assign shift_rot = (mode_q == SPG_MODE_ROTATE);

    assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> busy_q);
    assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q < len_q));
    assert_hold_no_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && enable && !tick) |=> (busy_q && $stable(cnt_q)));
    assert_settings_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($stable(len_q) && $stable(mode_q)));
    assert_disable_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !busy_q);
endmodule

// File: rtl/spg_active_shreg.sv
// Module: spg_active_shreg
// The active shift register. A load takes priority over a shift. A shift
// moves right by one, and the top bit takes either the outgoing bit 0
// (rotate) or 0. Two taps are brought out.
// Assumes: tap indices lie inside the register.
module spg_active_shreg #(
    parameter int ACT_W    = 64,
    parameter int DATA_TAP = 0,
    parameter int CLK_TAP  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic             rot,
    input  logic [ACT_W-1:0] load_val,
    output logic             tap_data,
    output logic             tap_clk
);
    logic [ACT_W-1:0] act_q;
    logic             fill;

    // Pick the bit that enters at the top on a shift.
    always_comb fill = rot ? act_q[0] : 1'b0;

    // Load or shift the active register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            act_q <= '0;
        else if (load)
            act_q <= load_val;
        else if (shift)
            act_q <= {fill, act_q[ACT_W-1:1]};
    end

    assign tap_data = act_q[DATA_TAP];
    assign tap_clk  = act_q[CLK_TAP];

    assert_shift_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (act_q[ACT_W-2:0] == $past(act_q[ACT_W-1:1])));
    assert_zero_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && !rot) |=> !act_q[ACT_W-1]);
    assert_rot_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && rot) |=> (act_q[ACT_W-1] == $past(act_q[0])));
    assert_load_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (act_q == $past(load_val)));
endmodule

// File: rtl/serial_pattern_gen.sv
// Module: serial_pattern_gen (top)
// Serial clock/data pattern generator. Shadow words feed a wide active shift
// register. The two outputs are taps of that register and are gated low
// while the generator is disabled.
// Assumes: DATA_TAP and CLK_TAP are below 2*REG_W.
module serial_pattern_gen #(
    parameter int REG_W    = 32,
    parameter int DATA_TAP = 0,
    parameter int CLK_TAP  = 16,
    localparam int ACT_W   = 2 * REG_W,
    localparam int LEN_W   = $clog2(ACT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic [LEN_W-1:0] bit_len,
    input  logic             mode,
    input  logic             enable,
    input  logic             start,
    input  logic             shift_tick,
    output logic             data_out,
    output logic             clk_out,
    output logic             busy
);
    import spg_pkg::*;

    logic [ACT_W-1:0] shadow_img;
    logic             out_en;
    logic             load_req;
    logic             shift_req;
    logic             shift_rot;
    logic             tap_data;
    logic             tap_clk;
    spg_mode_e        mode_e;

    assign mode_e = spg_mode_e'(mode);

    spg_shadow_regs #(.REG_W(REG_W)) u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .image   (shadow_img)
    );

    spg_burst_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .start     (start),
        .tick      (shift_tick),
        .bit_len   (bit_len),
        .mode      (mode_e),
        .busy      (busy),
        .out_en    (out_en),
        .load_req  (load_req),
        .shift_req (shift_req),
        .shift_rot (shift_rot)
    );

    spg_active_shreg #(
        .ACT_W    (ACT_W),
        .DATA_TAP (DATA_TAP),
        .CLK_TAP  (CLK_TAP)
    ) u_shreg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_req),
        .shift    (shift_req),
        .rot      (shift_rot),
        .load_val (shadow_img),
        .tap_data (tap_data),
        .tap_clk  (tap_clk)
    );

    // Gate the taps with the registered enable.
    always_comb begin
        data_out = out_en && tap_data;
        clk_out  = out_en && tap_clk;
    end

    assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!data_out && !clk_out));
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !data_out && !clk_out));
endmodule

// File: tb/serial_pattern_gen_tb_top.sv
// Bench: serial_pattern_gen_tb_top
// Drives the generator in a 16-bit configuration. It predicts every tap value
// from the pattern and the shift count and reports through counters.
module serial_pattern_gen_tb_top;
    localparam int REG_W = 8;
    localparam int DTAP  = 0;
    localparam int CTAP  = 4;
    localparam int AW    = 2 * REG_W;
    localparam int LW    = $clog2(AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [LW-1:0] bit_len = '0;
    logic          mode = 1'b0;
    logic          enable = 1'b0;
    logic          start = 1'b0;
    logic          shift_tick = 1'b0;
    logic          data_out;
    logic          clk_out;
    logic          busy;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    serial_pattern_gen #(.REG_W(REG_W), .DATA_TAP(DTAP), .CLK_TAP(CTAP)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .bit_len(bit_len), .mode(mode), .enable(enable),
        .start(start), .shift_tick(shift_tick), .data_out(data_out),
        .clk_out(clk_out), .busy(busy)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [2:0] obs();
        return {busy, data_out, clk_out};
    endfunction

    // Expected tap bit after k shifts of pattern p.
    function automatic logic expb(logic [AW-1:0] p, int k, int tap, logic rot);
        int idx;
        idx = k + tap;
        if (rot) return p[idx % AW];
        return (idx < AW) ? p[idx] : 1'b0;
    endfunction

    task automatic chk(string req, logic [2:0] act, logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s {busy,data,clk} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic write_word(logic sel, logic [REG_W-1:0] val);
        wr_en = 1'b1; wr_sel = sel; wr_data = val;
        step();
        wr_en = 1'b0;
    endtask

    task automatic load_pat(logic [AW-1:0] p);
        write_word(1'b0, p[REG_W-1:0]);
        write_word(1'b1, p[AW-1:REG_W]);
    endtask

    task automatic run_burst(logic [AW-1:0] p, int len, logic rot);
        load_pat(p);
        bit_len = LW'(len); mode = rot; start = 1'b1;
        step();
        start = 1'b0;
        chk("R5", obs(), {1'b1, expb(p, 0, DTAP, rot), expb(p, 0, CTAP, rot)});
        for (int k = 1; k <= len; k++) begin
            if (k % 2 == 1) begin
                start = 1'b1; bit_len = LW'(1); mode = ~rot;
                step();
                start = 1'b0; bit_len = LW'(len); mode = rot;
                chk("R9", obs(), {1'b1, expb(p, k-1, DTAP, rot), expb(p, k-1, CTAP, rot)});
            end
            shift_tick = 1'b1;
            step();
            shift_tick = 1'b0;
            if (k < len)
                chk("R6", obs(), {1'b1, expb(p, k, DTAP, rot), expb(p, k, CTAP, rot)});
            else if (rot)
                chk("R8", obs(), {1'b0, p[DTAP], p[CTAP]});
            else
                chk("R7", obs(), {1'b0, expb(p, len, DTAP, 1'b0), expb(p, len, CTAP, 1'b0)});
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R6 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] p;
        // R1: reset state.
        step(); step();
        chk("R1", obs(), 3'b000);
        rst_n = 1'b1;
        step();
        chk("R1", obs(), 3'b000);

        // R2: disabled outputs stay low with an all-ones pattern.
        load_pat(16'hFFFF);
        chk("R2", obs(), 3'b000);
        // R5: start while disabled is ignored.
        bit_len = LW'(3); start = 1'b1;
        step();
        start = 1'b0;
        chk("R5", obs(), 3'b000);

        // R4: rising enable loads the shadows.
        enable = 1'b1;
        step();
        chk("R4", obs(), 3'b011);
        // R3: writes alone do not reach the outputs.
        load_pat(16'h0000);
        chk("R3", obs(), 3'b011);

        // R5: zero length start is ignored.
        bit_len = '0; start = 1'b1;
        step();
        start = 1'b0;
        chk("R5", obs(), 3'b011);

        // Small-scale clock-idle example: data 1101, clock 1010, idle bit 1.
        enable = 1'b0;
        step();
        chk("R2", obs(), 3'b000);
        p = 16'h01AD;
        load_pat(p);
        enable = 1'b1;
        step();
        chk("R4", obs(), 3'b010);
        run_burst(p, 4, 1'b0);
        chk("R7", obs(), 3'b001);

        // Sweep of lengths, modes and patterns.
        for (int m = 0; m < 2; m++) begin
            for (int len = 1; len <= AW; len++) begin
                for (int v = 0; v < 2; v++) begin
                    p = AW'(16'hB4E1 * (len + 1) + v * 16'h3C5A + m * 16'h0F0F);
                    run_burst(p, len, m[0]);
                end
            end
        end

        // R10: disable during a burst.
        p = 16'h5A3C;
        load_pat(p);
        bit_len = LW'(10); mode = 1'b1; start = 1'b1;
        step();
        start = 1'b0;
        for (int k = 0; k < 3; k++) begin
            shift_tick = 1'b1; step(); shift_tick = 1'b0;
        end
        chk("R10", obs(), {1'b1, expb(p, 3, DTAP, 1'b1), expb(p, 3, CTAP, 1'b1)});
        enable = 1'b0;
        step();
        chk("R10", obs(), 3'b000);
        enable = 1'b1;
        step();
        chk("R4", obs(), {1'b0, p[DTAP], p[CTAP]});

        // R3: writes during a shift-once burst do not disturb it.
        p = 16'h3C96;
        load_pat(p);
        bit_len = LW'(6); mode = 1'b0; start = 1'b1;
        step();
        start = 1'b0;
        load_pat(16'hC369);
        chk("R3", obs(), {1'b1, p[DTAP], p[CTAP]});
        for (int k = 1; k <= 6; k++) begin
            shift_tick = 1'b1; step(); shift_tick = 1'b0;
        end
        chk("R7", obs(), {1'b0, expb(p, 6, DTAP, 1'b0), expb(p, 6, CTAP, 1'b0)});

        // R8: rotate-once reloads the shadows as they stand at the end.
        p = 16'h3C96;
        load_pat(p);
        bit_len = LW'(5); mode = 1'b1; start = 1'b1;
        step();
        start = 1'b0;
        load_pat(16'hC369);
        for (int k = 1; k <= 5; k++) begin
            shift_tick = 1'b1; step(); shift_tick = 1'b0;
        end
        p = 16'hC369;
        chk("R8", obs(), {1'b0, p[DTAP], p[CTAP]});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule